// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block is the digital protection controller that sits between a motor or power-stage controller and the six gate outputs of a three-phase half-bridge driver. It takes the six gate commands (one high-side and one low-side per phase), a drive-enable input, a digitised over-current comparator flag, a low-side supply undervoltage flag and a user clear request. From these it produces the six gated gate outputs, a global kill indication and an active-low, open-drain-style fault flag. A value of 1 on the fault flag means the pin is released (high impedance), and 0 means it is pulled low.

Every command input and the enable pass through a glitch filter. The over-current flag must stay high through a blanking window before it counts as a trip. A qualified trip sets a set-dominant fault latch, and while the latch is set all six gates are forced off. The latch is released by a clear counter that stands in for an external RC ramp, or by the clear request. Either way the over-current flag must already be low. Undervoltage forces the outputs off and pulls the fault flag low only while the undervoltage flag is present; it never sets the latch. After reset the latch starts set, so the outputs stay off until one full clear delay has elapsed.

Top module: `gdrv_fault_sup`

## Requirements
- R1: After reset the fault latch is set: `kill_o`=1, `flt_n_o`=0 and all six gates are 0. With `itrip_i` low the latch releases at exactly the CLR_CYC-th rising edge after reset is removed.
- R2: `drv_en_i` and each bit of `hi_cmd_i`/`lo_cmd_i` take effect only after the input has held its new value for FILT_CYC consecutive rising edges. The filtered value changes at exactly the FILT_CYC-th edge, and a shorter excursion has no effect at the outputs.
- R3: Bit k of `hi_gate_o` is 1 only when the filtered high command k is 1 and the filtered low command k is 0, and the same rule holds with the two sides exchanged. A phase never drives both of its gates high.
- R4: `itrip_i` sets the fault latch only when it has been sampled high on BLANK_CYC consecutive rising edges. The latch sets at exactly that edge, and a shorter pulse leaves `flt_n_o` at 1.
- R5: While the fault latch is set, all six gate outputs are 0, `kill_o`=1 and `flt_n_o`=0.
- R6: The latch is set-dominant. While `itrip_i` is high, neither `clr_req_i` nor the passage of time releases it.
- R7: Once `itrip_i` is low with the latch set, the latch releases at the CLR_CYC-th consecutive rising edge with `itrip_i` low.
- R8: `clr_req_i`=1 with `itrip_i`=0 releases a set latch at the next rising edge.
- R9: `uv_i`=1 forces all six gates to 0 and `flt_n_o`=0 in the same cycle, without any clock edge. Once `uv_i` returns to 0, `flt_n_o` returns to 1 and the gates follow their commands again, because undervoltage is never latched.
- R10: A filtered enable of 0 forces all six gates to 0 and `kill_o`=1, and leaves `flt_n_o` at 1.
- R11: `kill_o` is 1 exactly when the latch is set, `uv_i` is 1 or the filtered enable is 0. Whenever `kill_o` is 1, all gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_en_i | input | 1 | Drive enable; 0 forces all gates off |
| hi_cmd_i | input | N_PH | High-side gate commands, one per phase |
| lo_cmd_i | input | N_PH | Low-side gate commands, one per phase |
| itrip_i | input | 1 | Digitised over-current comparator flag |
| uv_i | input | 1 | Low-side supply undervoltage flag |
| clr_req_i | input | 1 | User request to clear the fault latch |
| hi_gate_o | output | N_PH | Gated high-side outputs |
| lo_gate_o | output | N_PH | Gated low-side outputs |
| kill_o | output | 1 | All gates forced off |
| flt_n_o | output | 1 | Fault flag: 0 = pulled low, 1 = released |

## Verification
A latch that is wrongly left set shows at once as `flt_n_o` low and every gate stuck at 0. A latch that is wrongly clear shows as gates that keep following their commands during a trip, one cycle after the qualifying edge. An off-by-one in the blanking, filter or clear counters moves the edge at which `flt_n_o` or a gate changes by one cycle, so the bench samples the cycle before and the cycle of each expected transition. A broken interlock shows as both gates of one phase at 1 in the command sweep.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_t;

  // counter width able to hold values 0..lim
  function automatic int unsigned cnt_w(input int unsigned lim);
    int unsigned w;
    w = $clog2(lim + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // one phase leg: interlocked and masked by the global allow
  function automatic leg_t leg_drive(input logic h, input logic l, input logic allow);
    leg_t r;
    r.hi = allow & h & ~l;
    r.lo = allow & l & ~h;
    return r;
  endfunction

endpackage

// File: rtl/gdrv_glitch_filt.sv
module gdrv_glitch_filt
  import gdrv_pkg::*;
#(
  parameter int unsigned CYC  = 20,
  parameter logic        INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);

  localparam int unsigned    CW   = cnt_w(CYC);
  localparam logic [CW-1:0]  LAST = CW'(CYC - 1);

  logic          q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= INIT;
      cnt <= '0;
    end else if (raw_i == q) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      q   <= raw_i;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign clean_o = q;

endmodule

// File: rtl/gdrv_trip_latch.sv
module gdrv_trip_latch
  import gdrv_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 15,
  parameter int unsigned CLR_CYC   = 165000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic itrip_i,
  input  logic clr_req_i,
  output logic latch_o,
  output logic trip_set_o,
  output logic clr_done_o
);

  localparam int unsigned   BW    = cnt_w(BLANK_CYC);
  localparam int unsigned   CW    = cnt_w(CLR_CYC);
  localparam logic [BW-1:0] BLAST = BW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] CLAST = CW'(CLR_CYC - 1);

  logic [BW-1:0] bcnt;
  logic [CW-1:0] ccnt;
  logic          latch_q;
  logic          rel_ok;

  // blanking: consecutive high samples of the trip flag, saturating
  always_ff @(posedge clk) begin
    if (!rst_n || !itrip_i) bcnt <= '0;
    else if (bcnt != BLAST) bcnt <= bcnt + 1'b1;
  end

  assign trip_set_o = itrip_i && (bcnt == BLAST);

  // clear delay: runs only while latched with the trip flag low
  assign clr_done_o = latch_q && !itrip_i && (ccnt == CLAST);
  assign rel_ok     = latch_q && !itrip_i && (clr_done_o || clr_req_i);

  always_ff @(posedge clk) begin
    if (!rst_n || !latch_q || itrip_i) ccnt <= '0;
    else if (ccnt != CLAST) ccnt <= ccnt + 1'b1;
  end

  // set-dominant latch, set out of reset
  always_ff @(posedge clk) begin
    if (!rst_n)          latch_q <= 1'b1;
    else if (trip_set_o) latch_q <= 1'b1;
    else if (rel_ok)     latch_q <= 1'b0;
  end

  assign latch_o = latch_q;

endmodule

// File: rtl/gdrv_gate_mask.sv
module gdrv_gate_mask
  import gdrv_pkg::*;
#(
  parameter int unsigned N_PH = 3
) (
  input  logic [N_PH-1:0] hi_f_i,
  input  logic [N_PH-1:0] lo_f_i,
  input  logic            allow_i,
  output logic [N_PH-1:0] hi_gate_o,
  output logic [N_PH-1:0] lo_gate_o
);

  for (genvar k = 0; k < N_PH; k++) begin : g_leg
    leg_t leg;
    assign leg          = leg_drive(hi_f_i[k], lo_f_i[k], allow_i);
    assign hi_gate_o[k] = leg.hi;
    assign lo_gate_o[k] = leg.lo;
  end

endmodule

// File: rtl/gdrv_fault_sup.sv
module gdrv_fault_sup #(
  parameter int unsigned N_PH      = 3,
  parameter int unsigned BLANK_CYC = 15,
  parameter int unsigned FILT_CYC  = 20,
  parameter int unsigned CLR_CYC   = 165000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drv_en_i,
  input  logic [N_PH-1:0] hi_cmd_i,
  input  logic [N_PH-1:0] lo_cmd_i,
  input  logic            itrip_i,
  input  logic            uv_i,
  input  logic            clr_req_i,
  output logic [N_PH-1:0] hi_gate_o,
  output logic [N_PH-1:0] lo_gate_o,
  output logic            kill_o,
  output logic            flt_n_o
);

  // named internal events (also observed by the bound checker)
  logic            en_flt;
  logic [N_PH-1:0] hi_flt;
  logic [N_PH-1:0] lo_flt;
  logic            latch_q;
  logic            trip_set;
  logic            clr_done;

  gdrv_glitch_filt #(.CYC(FILT_CYC), .INIT(1'b0)) u_en_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(drv_en_i), .clean_o(en_flt)
  );

  for (genvar k = 0; k < N_PH; k++) begin : g_cmd
    gdrv_glitch_filt #(.CYC(FILT_CYC), .INIT(1'b0)) u_hi_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(hi_cmd_i[k]), .clean_o(hi_flt[k])
    );
    gdrv_glitch_filt #(.CYC(FILT_CYC), .INIT(1'b0)) u_lo_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(lo_cmd_i[k]), .clean_o(lo_flt[k])
    );
  end

  gdrv_trip_latch #(.BLANK_CYC(BLANK_CYC), .CLR_CYC(CLR_CYC)) u_trip (
    .clk(clk), .rst_n(rst_n), .itrip_i(itrip_i), .clr_req_i(clr_req_i),
    .latch_o(latch_q), .trip_set_o(trip_set), .clr_done_o(clr_done)
  );

  assign kill_o  = latch_q | uv_i | ~en_flt;
  assign flt_n_o = ~(latch_q | uv_i);

  gdrv_gate_mask #(.N_PH(N_PH)) u_mask (
    .hi_f_i(hi_flt), .lo_f_i(lo_flt), .allow_i(~kill_o),
    .hi_gate_o(hi_gate_o), .lo_gate_o(lo_gate_o)
  );

endmodule

// File: rtl/gdrv_fault_sup_chk.sv
module gdrv_fault_sup_chk #(
  parameter int unsigned N_PH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            itrip_i,
  input logic            uv_i,
  input logic            clr_req_i,
  input logic [N_PH-1:0] hi_gate_o,
  input logic [N_PH-1:0] lo_gate_o,
  input logic            kill_o,
  input logic            flt_n_o,
  input logic            latch_q,
  input logic            trip_set,
  input logic            clr_done,
  input logic            en_flt
);

  // R3
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_gate_o & lo_gate_o) == '0);

  // R5
  trip_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_set |=> (!flt_n_o && kill_o && ({hi_gate_o, lo_gate_o} == '0)));

  // R6
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && itrip_i) |=> latch_q);

  // R7
  clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_q) |-> $past(!itrip_i && (clr_req_i || clr_done)));

  // R4
  blank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(itrip_i));

  // R9
  uv_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |-> (!flt_n_o && ({hi_gate_o, lo_gate_o} == '0)));

  // R10
  en_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_flt && !latch_q && !uv_i) |-> (flt_n_o && kill_o && ({hi_gate_o, lo_gate_o} == '0)));

  // R11
  kill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_o |-> ({hi_gate_o, lo_gate_o} == '0));

endmodule

bind gdrv_fault_sup gdrv_fault_sup_chk #(.N_PH(N_PH)) u_chk (
  .clk(clk), .rst_n(rst_n), .itrip_i(itrip_i), .uv_i(uv_i), .clr_req_i(clr_req_i),
  .hi_gate_o(hi_gate_o), .lo_gate_o(lo_gate_o), .kill_o(kill_o), .flt_n_o(flt_n_o),
  .latch_q(latch_q), .trip_set(trip_set), .clr_done(clr_done), .en_flt(en_flt)
);

// File: tb/gdrv_fault_sup_tb.sv
module gdrv_fault_sup_tb;

  localparam int CLK_P = 10;
  localparam int BLANK = 3;
  localparam int FILT  = 4;
  localparam int CLR   = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drv_en = 1'b0;
  logic [5:0] cmd6 = '0;   // [2:0] high-side, [5:3] low-side
  logic       itrip = 1'b0;
  logic       uv = 1'b0;
  logic       clr_req = 1'b0;
  logic [2:0] hi_gate, lo_gate;
  logic       kill, flt_n;
  logic [5:0] gates6;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  assign gates6 = {lo_gate, hi_gate};

  always #(CLK_P/2) clk = ~clk;

  gdrv_fault_sup #(.N_PH(3), .BLANK_CYC(BLANK), .FILT_CYC(FILT), .CLR_CYC(CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .drv_en_i(drv_en), .hi_cmd_i(cmd6[2:0]), .lo_cmd_i(cmd6[5:3]),
    .itrip_i(itrip), .uv_i(uv), .clr_req_i(clr_req),
    .hi_gate_o(hi_gate), .lo_gate_o(lo_gate), .kill_o(kill), .flt_n_o(flt_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  function automatic logic [5:0] exp_gates(input logic [5:0] c);
    logic [2:0] h, l;
    h = c[2:0];
    l = c[5:3];
    return {l & ~h, h & ~l};
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1: latched out of reset
    chk("R1 kill after reset", kill, 1);
    chk("R1 flt_n after reset", flt_n, 0);
    chk("R1 gates after reset", gates6, 0);
    tick(CLR - 1);
    chk("R1 latch held until clear delay", flt_n, 0);
    tick(1);
    chk("R1 latch released at clear delay", flt_n, 1);
    chk("R10 kill while enable filtered low", kill, 1);

    // R2: enable latency
    drv_en = 1'b1;
    tick(FILT - 1);
    chk("R2 enable before filter time", kill, 1);
    tick(1);
    chk("R2 enable at filter time", kill, 0);

    // R2: exact latency on one command
    cmd6 = 6'b010000;
    tick(FILT - 1);
    chk("R2 cmd before filter time", gates6, 0);
    tick(1);
    chk("R2 cmd at filter time", gates6, 6'b010000);
    cmd6 = '0;
    tick(FILT + 1);

    // R2: pulse width sweep on every channel
    for (int ch = 0; ch < 6; ch++) begin
      for (int w = 1; w <= FILT + 1; w++) begin
        logic seen;
        seen = 1'b0;
        cmd6[ch] = 1'b1;
        for (int i = 0; i < w; i++) begin tick(1); seen |= gates6[ch]; end
        cmd6[ch] = 1'b0;
        for (int i = 0; i < FILT + 2; i++) begin tick(1); seen |= gates6[ch]; end
        chk($sformatf("R2 pulse ch%0d w%0d", ch, w), seen, (w >= FILT));
        chk("R2 idle after pulse", gates6, 0);
      end
    end

    // R3: interlock over all command combinations
    for (int v = 0; v < 64; v++) begin
      cmd6 = 6'(v);
      tick(FILT + 1);
      chk($sformatf("R3 interlock cmd %02h", v), gates6, exp_gates(6'(v)));
    end

    // R2 and R10: enable glitch then real enable drop
    cmd6 = 6'b000001;
    tick(FILT + 1);
    chk("R10 gate on before enable drop", gates6, 6'b000001);
    begin
      logic dropped;
      dropped = 1'b0;
      drv_en = 1'b0;
      for (int i = 0; i < FILT - 1; i++) begin tick(1); dropped |= ~gates6[0]; end
      drv_en = 1'b1;
      for (int i = 0; i < FILT + 1; i++) begin tick(1); dropped |= ~gates6[0]; end
      chk("R2 short enable low rejected", dropped, 0);
    end
    drv_en = 1'b0;
    tick(FILT - 1);
    chk("R10 gate still on before enable filter", gates6, 6'b000001);
    tick(1);
    chk("R10 gates off with enable low", gates6, 0);
    chk("R11 kill with enable low", kill, 1);
    chk("R10 flt_n stays released", flt_n, 1);
    drv_en = 1'b1;
    tick(FILT + 1);

    // R4 and R5: blanking sweep
    cmd6 = 6'b010101;
    tick(FILT + 1);
    chk("R3 mixed legs", gates6, 6'b010101);
    for (int w = 1; w <= BLANK + 1; w++) begin
      itrip = 1'b1;
      tick(w);
      itrip = 1'b0;
      tick(1);
      chk($sformatf("R4 blank pulse w%0d", w), flt_n, (w < BLANK));
      chk($sformatf("R5 gates on trip w%0d", w), gates6, (w >= BLANK) ? 6'b0 : 6'b010101);
      tick(CLR);
      chk("R7 released after clear delay", flt_n, 1);
      chk("R7 gates restored", gates6, 6'b010101);
    end

    // R4: exact trip edge
    itrip = 1'b1;
    tick(BLANK - 1);
    chk("R4 no trip before blank end", flt_n, 1);
    tick(1);
    chk("R5 flt_n at blank end", flt_n, 0);
    chk("R11 kill on trip", kill, 1);
    chk("R5 gates off on trip", gates6, 0);

    // R6: set-dominant
    clr_req = 1'b1;
    tick(2);
    clr_req = 1'b0;
    chk("R6 clear request ignored while tripped", flt_n, 0);
    tick(CLR + 5);
    chk("R6 no timed clear while tripped", flt_n, 0);

    // R7: exact clear edge
    itrip = 1'b0;
    tick(CLR - 1);
    chk("R7 held before clear delay", flt_n, 0);
    tick(1);
    chk("R7 released at clear delay", flt_n, 1);

    // R8: user clear
    itrip = 1'b1;
    tick(BLANK);
    chk("R8 tripped before clear request", flt_n, 0);
    itrip = 1'b0;
    clr_req = 1'b1;
    tick(1);
    clr_req = 1'b0;
    chk("R8 clear request releases at next edge", flt_n, 1);
    chk("R8 gates back", gates6, 6'b010101);

    // R9: undervoltage not latched
    @(posedge clk);
    #1;
    uv = 1'b1;
    #1;
    chk("R9 flt_n low on undervoltage", flt_n, 0);
    chk("R9 gates off on undervoltage", gates6, 0);
    chk("R11 kill on undervoltage", kill, 1);
    tick(3);
    uv = 1'b0;
    #1;
    chk("R9 flt_n released after undervoltage", flt_n, 1);
    chk("R9 gates resume after undervoltage", gates6, 6'b010101);
    chk("R11 kill clear", kill, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule